// File: doc/BRIEF.md
# DMA Trigger Selector and Channel Arbiter

This block sits in front of three DMA channel engines and decides which of them may use the memory bus next. Each channel owns a 5-bit source-select field that picks one line from a 32-wide bundle of hardware request lines. Code 0 in that field does not pick a hardware line. It picks the channel's own software request bit instead. Each channel also has a mode bit. In edge mode, a rising edge on the chosen line is remembered as a pending request. In level mode, the line requests service for as long as it stays high.

When several channels want the bus, a small two-state controller grants exactly one of them. The states are `ST_IDLE` and `ST_GRANT`. The transition `ST_IDLE -> ST_GRANT` (start) fires when some channel requests and the bus is not reserved. The transition `ST_GRANT -> ST_GRANT` (hold) keeps the grant stable while the owning channel has not finished its step. The transition `ST_GRANT -> ST_IDLE` (release) fires when that channel reports its step done. Without rotation the order is fixed, with channel 0 first. With rotation enabled, the channel most recently granted drops to the back of the order.

A bus-reserve input stops new grants and discards triggers while the bus is held for other work, such as a non-maskable interrupt or reprogramming of the channels.

Top module: `dma_trig_arb`

## Requirements
- R1: For channel c, select code 0 takes `sw_req_i[c]` as the trigger source. A code k of 1 to 31 takes `hw_req_i[k]`. `hw_req_i[0]` never causes a grant. Channel c's field is `src_sel_i[5c+4:5c]`.
- R2: In edge mode (`level_mode_i[c]`=0), a 0-to-1 change of the selected source is stored as pending until that channel is granted. One edge yields exactly one grant.
- R3: In level mode (`level_mode_i[c]`=1), the channel requests only while the selected source is high. Nothing is stored, so a level that falls before it can be granted leaves no trace.
- R4: While `bus_hold_i` is high, no new grant starts. A rising edge seen during the hold is discarded. A level request is granted once the hold drops, if the level is still high.
- R5: With `rotate_en_i`=0, simultaneous requests are served in the order channel 0, then 1, then 2.
- R6: With `rotate_en_i`=1, the channel just granted becomes lowest priority. After reset the order starts at channel 0.
- R7: `grant_o` is one-hot or zero. A grant stays unchanged until `step_done_i` has the granted channel's bit set. Done bits of other channels are ignored.
- R8: A grant appears on the clock edge at which the request is visible to the controller. A level request is visible on the first edge at which the source is high. An edge request is visible one edge after the source rises. The grant drops on the edge where done is seen. After that, at least one cycle without a grant passes before the next grant.
- R9: `busy_o` is high while a grant is active or any edge request is pending.
- R10: After reset, `grant_o` is 0, `busy_o` is 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req_i | input | 32 | Hardware request lines; line 0 unused |
| sw_req_i | input | 3 | Per-channel software request bit (source code 0) |
| src_sel_i | input | 15 | Three 5-bit source-select fields, channel 0 in the low bits |
| level_mode_i | input | 3 | Per-channel trigger mode: 1 level, 0 edge |
| rotate_en_i | input | 1 | 1 selects rotating priority, 0 fixed |
| bus_hold_i | input | 1 | Bus reserved: block new grants and drop triggers |
| step_done_i | input | 3 | Per-channel transfer-step completion |
| grant_o | output | 3 | One-hot grant to the channel engines |
| busy_o | output | 1 | Grant active or edge request pending |

## Verification
The bench targets these corner cases:
- **Edge that rises during a hold and stays high.** A design that compares only against the value seen at release would grant the edge late.
- **Level that comes and goes entirely inside a hold.** A design that latched level requests would grant a stale request.
- **Two edge requests arriving together.** A lost pending bit would serve only channel 0.
- **Done asserted for a channel that does not hold the grant.** A design that ignores the done mask would release the bus early.
- **Continuous requests on all channels under rotation.** A wrong pointer update would repeat a channel instead of cycling 0, 1, 2, 0.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dma_trig_chan.sv
// One channel's source multiplexer and trigger detector.
module dma_trig_chan #(
    parameter int SEL_W   = 5,
    parameter int NUM_SRC = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_req,
    input  logic               sw_req,
    input  logic [SEL_W-1:0]   sel,
    input  logic               level_mode,
    input  logic               hold,
    input  logic               clr,
    output logic               req,
    output logic               pend
);
    logic src;
    logic src_prev;
    logic rise;
    logic pend_q;

    // Code 0 routes the software bit; line 0 of the bundle is never used.
    always_comb begin
        if (sel == '0) src = sw_req;
        else           src = hw_req[sel];
    end

    assign rise = src & ~src_prev & ~level_mode;

    // History keeps tracking during a hold, so an edge there is consumed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_prev <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            src_prev <= src;
            pend_q   <= (pend_q & ~clr) | (rise & ~hold);
        end
    end

    assign req  = level_mode ? (src & ~hold) : pend_q;
    assign pend = pend_q;
endmodule

// File: rtl/dma_trig_pick.sv
// Selects one requesting channel: fixed order or rotating after last winner.
module dma_trig_pick #(
    parameter int NUM_CH = 3,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [CH_W-1:0]   last,
    input  logic              rotate,
    output logic [NUM_CH-1:0] pick,
    output logic [CH_W-1:0]   pick_idx
);
    always_comb begin
        pick     = '0;
        pick_idx = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            int j;
            if (rotate) begin
                j = int'(last) + 1 + i;
                if (j >= NUM_CH) j = j - NUM_CH;
            end else begin
                j = i;
            end
            if (pick == '0 && req[j]) begin
                pick[j]  = 1'b1;
                pick_idx = CH_W'(j);
            end
        end
    end
endmodule

// File: rtl/dma_trig_arb.sv
module dma_trig_arb #(
    parameter int NUM_CH  = 3,
    parameter int SEL_W   = 5,
    parameter int NUM_SRC = 1 << SEL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      hw_req_i,
    input  logic [NUM_CH-1:0]       sw_req_i,
    input  logic [NUM_CH*SEL_W-1:0] src_sel_i,
    input  logic [NUM_CH-1:0]       level_mode_i,
    input  logic                    rotate_en_i,
    input  logic                    bus_hold_i,
    input  logic [NUM_CH-1:0]       step_done_i,
    output logic [NUM_CH-1:0]       grant_o,
    output logic                    busy_o
);
    import dma_trig_pkg::*;

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    arb_state_e        state_q, state_d;
    logic [NUM_CH-1:0] grant_q;
    logic [CH_W-1:0]   last_q;
    logic [NUM_CH-1:0] ch_req, ch_pend, ch_clr;
    logic [NUM_CH-1:0] pick;
    logic [CH_W-1:0]   pick_idx;
    logic              start, release_grant;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dma_trig_chan #(.SEL_W(SEL_W), .NUM_SRC(NUM_SRC)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .hw_req     (hw_req_i),
            .sw_req     (sw_req_i[c]),
            .sel        (src_sel_i[c*SEL_W +: SEL_W]),
            .level_mode (level_mode_i[c]),
            .hold       (bus_hold_i),
            .clr        (ch_clr[c]),
            .req        (ch_req[c]),
            .pend       (ch_pend[c])
        );
    end

    dma_trig_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .req      (ch_req),
        .last     (last_q),
        .rotate   (rotate_en_i),
        .pick     (pick),
        .pick_idx (pick_idx)
    );

    assign start         = (state_q == ST_IDLE) && (|ch_req) && !bus_hold_i;
    assign release_grant = (state_q == ST_GRANT) && (|(step_done_i & grant_q));
    assign ch_clr        = start ? pick : '0;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)         state_d = ST_GRANT;
            ST_GRANT: if (release_grant) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // State register with grant and rotation pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
            last_q  <= CH_W'(NUM_CH - 1);
        end else begin
            state_q <= state_d;
            if (start) begin
                grant_q <= pick;
                last_q  <= pick_idx;
            end else if (release_grant) begin
                grant_q <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        grant_o = grant_q;
        busy_o  = (state_q == ST_GRANT) || (|ch_pend);
    end
endmodule

// File: rtl/dma_trig_arb_chk.sv
module dma_trig_arb_chk #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] grant_o,
    input logic [NUM_CH-1:0] step_done_i,
    input logic              bus_hold_i,
    input logic              busy_o
);
    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R7
    grant_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && (step_done_i & grant_o) == '0) |=> $stable(grant_o));

    // R8
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_done_i & grant_o) != '0) |=> grant_o == '0);

    // R4
    hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o == '0 && bus_hold_i) |=> grant_o == '0);

    // R9
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> busy_o);
endmodule

bind dma_trig_arb dma_trig_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_o     (grant_o),
    .step_done_i (step_done_i),
    .bus_hold_i  (bus_hold_i),
    .busy_o      (busy_o)
);

// File: tb/dma_trig_arb_tb.sv
`timescale 1ns/1ps
module dma_trig_arb_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] hw_req_i;
    logic [2:0]  sw_req_i;
    logic [14:0] src_sel_i;
    logic [2:0]  level_mode_i;
    logic        rotate_en_i;
    logic        bus_hold_i;
    logic [2:0]  step_done_i;
    logic [2:0]  grant_o;
    logic        busy_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dma_trig_arb u_dut (
        .clk(clk), .rst_n(rst_n), .hw_req_i(hw_req_i), .sw_req_i(sw_req_i),
        .src_sel_i(src_sel_i), .level_mode_i(level_mode_i),
        .rotate_en_i(rotate_en_i), .bus_hold_i(bus_hold_i),
        .step_done_i(step_done_i), .grant_o(grant_o), .busy_o(busy_o)
    );

    // {request mask ch2..ch0, expected grant} for fixed order, level mode
    localparam logic [5:0] VEC [8] = '{
        6'b000_000, 6'b001_001, 6'b010_010, 6'b011_001,
        6'b100_100, 6'b101_001, 6'b110_010, 6'b111_001
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive_mask(input logic [2:0] m);
        hw_req_i[3]  = m[0];
        hw_req_i[7]  = m[1];
        hw_req_i[20] = m[2];
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        hw_req_i = '0; sw_req_i = '0; rotate_en_i = 0; bus_hold_i = 0;
        step_done_i = '0; level_mode_i = 3'b111;
        src_sel_i = {5'd20, 5'd7, 5'd3};
        @(negedge clk);
        do_reset();
        chk("R10 grant", grant_o, 3'b000);
        chk("R10 busy", {2'b0, busy_o}, 3'b000);

        // Table: fixed priority among simultaneous level requests
        for (int v = 0; v < 8; v++) begin
            drive_mask(VEC[v][5:3]);
            tick();
            chk("R5 fixed order", grant_o, VEC[v][2:0]);
            drive_mask(3'b000);
            step_done_i = VEC[v][2:0];
            tick();
            step_done_i = '0;
            chk("R8 release", grant_o, 3'b000);
        end

        // R1: line 0 ignored, code 0 uses software bit
        src_sel_i = {5'd0, 5'd7, 5'd3};
        hw_req_i[0] = 1'b1;
        tick();
        chk("R1 line0 ignored", grant_o, 3'b000);
        hw_req_i[0] = 1'b0;
        sw_req_i = 3'b100;
        tick();
        chk("R1 software source", grant_o, 3'b100);
        sw_req_i = '0; step_done_i = 3'b100;
        tick();
        step_done_i = '0;
        src_sel_i = {5'd20, 5'd7, 5'd3};

        // R2/R8/R7/R9: one-cycle edge on channel 1
        level_mode_i = 3'b101;
        tick();
        hw_req_i[7] = 1'b1;
        tick();
        chk("R8 edge not yet granted", grant_o, 3'b000);
        chk("R9 busy on pending", {2'b0, busy_o}, 3'b001);
        hw_req_i[7] = 1'b0;
        tick();
        chk("R2 edge granted", grant_o, 3'b010);
        repeat (3) tick();
        chk("R7 grant held", grant_o, 3'b010);
        step_done_i = 3'b001;
        tick();
        chk("R7 foreign done ignored", grant_o, 3'b010);
        step_done_i = 3'b010;
        tick();
        step_done_i = '0;
        chk("R8 drop on done", grant_o, 3'b000);
        tick();
        chk("R2 single grant per edge", grant_o, 3'b000);
        chk("R9 idle not busy", {2'b0, busy_o}, 3'b000);

        // R2/R5: two edges together, both served
        level_mode_i = 3'b000;
        tick();
        drive_mask(3'b011);
        tick();
        drive_mask(3'b000);
        tick();
        chk("R5 edge pair first", grant_o, 3'b001);
        step_done_i = 3'b001;
        tick();
        step_done_i = '0;
        chk("R8 gap cycle", grant_o, 3'b000);
        chk("R9 busy with pending", {2'b0, busy_o}, 3'b001);
        tick();
        chk("R2 edge pair second", grant_o, 3'b010);
        step_done_i = 3'b010;
        tick();
        step_done_i = '0;

        // R4: edge rising during hold is discarded
        bus_hold_i = 1'b1;
        hw_req_i[7] = 1'b1;
        repeat (2) tick();
        chk("R4 no grant in hold", grant_o, 3'b000);
        bus_hold_i = 1'b0;
        repeat (2) tick();
        chk("R4 held edge dropped", grant_o, 3'b000);
        hw_req_i[7] = 1'b0;

        // R3/R4: level inside hold leaves nothing; level across hold granted
        level_mode_i = 3'b100;
        bus_hold_i = 1'b1;
        hw_req_i[20] = 1'b1;
        tick();
        chk("R4 level blocked", grant_o, 3'b000);
        hw_req_i[20] = 1'b0;
        bus_hold_i = 1'b0;
        tick();
        chk("R3 level not stored", grant_o, 3'b000);
        bus_hold_i = 1'b1;
        hw_req_i[20] = 1'b1;
        tick();
        bus_hold_i = 1'b0;
        tick();
        chk("R4 level after hold", grant_o, 3'b100);
        hw_req_i[20] = 1'b0;
        step_done_i = 3'b100;
        tick();
        step_done_i = '0;

        // R5: fixed order does not rotate under continuous requests
        level_mode_i = 3'b111;
        drive_mask(3'b111);
        tick();
        chk("R5 fixed first", grant_o, 3'b001);
        step_done_i = 3'b001;
        tick();
        step_done_i = '0;
        tick();
        chk("R5 fixed repeat", grant_o, 3'b001);
        drive_mask(3'b000);
        step_done_i = 3'b001;
        tick();
        step_done_i = '0;

        // R6: rotation cycles through all channels
        do_reset();
        rotate_en_i = 1'b1;
        drive_mask(3'b111);
        tick();
        begin
            logic [2:0] exp_seq [4];
            exp_seq = '{3'b001, 3'b010, 3'b100, 3'b001};
            for (int k = 0; k < 4; k++) begin
                chk("R6 rotate order", grant_o, exp_seq[k]);
                step_done_i = exp_seq[k];
                tick();
                step_done_i = '0;
                tick();
            end
        end
        drive_mask(3'b000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule